// File: doc/BRIEF.md
# Ping-Pong Input Buffer Selector

This block decides which of two equal-sized input buffers, called A and B, takes the next bytes arriving on a bulk data endpoint. It keeps a byte count for the most recent fill of each buffer. A CPU reaches it through one 8-bit control register. That register holds the transfer direction, the buffer selection, a write qualifier for the selection, and a sticky wrong-direction error flag. The buffer memories and the storage-side interface sit outside the block. The block only tracks selection and counts, and drives the two counts out.

Software picks a buffer by writing the register with the qualifier bit set. That write also zeroes the chosen buffer's count. Each pulse of the byte-write strobe adds one to the count of the selected buffer, and the count stops at the buffer size. With the auto-toggle input high, a strobe that fills the selected buffer moves the selection to the other buffer and zeroes that buffer's count. Tokens that go against the programmed direction raise the error flag.

Top module: `ppb_select`

## Requirements
- R1: After a synchronous reset the register reads 0x00, buffer A is selected, both counts are 0 and the error flag is 0.
- R2: Bit 7 (direction; 1 = storage side toward USB engine) is loaded on every register write and reads back as written.
- R3: Bit 5 (selection; 0 = A, 1 = B) changes on a register write only when bit 6 of that write is 1; otherwise the selection is unchanged.
- R4: Bit 6 of the register always reads 0.
- R5: A write that selects a buffer zeroes that buffer's count after the clock edge and leaves the other count unchanged.
- R6: A byte-write strobe adds one to the selected buffer's count after the edge and leaves the other count alone; if a selecting write happens in the same cycle, the write wins and the strobe is dropped.
- R7: With auto-toggle low, a count holds at BUF_BYTES when further strobes arrive.
- R8: With auto-toggle high, a strobe that leaves the selected count at BUF_BYTES also switches the selection to the other buffer (bit 5 follows it) and zeroes that buffer's count.
- R9: A valid token sets the error flag (read at bit 0) when it is an OUT token and bit 7 is 1, or an IN token and bit 7 is 0; a token in the matching direction leaves the flag unchanged.
- R10: The error flag stays set until a register write with bit 0 = 1 clears it; a write with bit 0 = 0 leaves it set, and a set condition in the same cycle as a clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | CPU write strobe for the control register |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read value |
| auto_toggle | input | 1 | Enables automatic buffer switching when a buffer fills |
| byte_wr | input | 1 | One byte written into the selected buffer |
| tok_valid | input | 1 | A token was received on the endpoint |
| tok_is_in | input | 1 | 1 = IN token, 0 = OUT token |
| buf_sel | output | 1 | Current buffer (0 = A, 1 = B) |
| cnt_a | output | CNT_W | Byte count of buffer A |
| cnt_b | output | CNT_W | Byte count of buffer B |
| ep_err | output | 1 | Sticky wrong-direction error |
| xfer_dir | output | 1 | Programmed transfer direction |

## Verification
The bench builds the block with BUF_BYTES = 8, so the counts are 4 bits wide. With that size, saturation and the auto-toggle switch each take only a handful of strobes. The same comparisons against BUF_BYTES and BUF_BYTES-1 run at the default size of 512. The smaller size also lets one short run cover a selection change in both directions, a strobe that collides with a selecting write, and a token that coincides with a clearing write.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned BIT_DIR    = 7;
  localparam int unsigned BIT_TVALID = 6;
  localparam int unsigned BIT_TOG    = 5;
  localparam int unsigned BIT_ERR    = 0;

  typedef enum logic {
    BUF_A = 1'b0,
    BUF_B = 1'b1
  } buf_id_e;
endpackage

// File: rtl/ppb_byte_cnt.sv
module ppb_byte_cnt #(
  parameter int unsigned LIMIT = 512,
  parameter int unsigned CNT_W = $clog2(LIMIT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && count != LIM_V) begin
      count <= count + 1'b1;
    end
  end

  // R7: a count never passes the buffer size
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= LIM_V);

  // R5: a clear request empties the count at the next edge
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
endmodule

// File: rtl/ppb_sel_ctrl.sv
module ppb_sel_ctrl #(
  parameter int unsigned LIMIT = 512,
  parameter int unsigned CNT_W = $clog2(LIMIT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_sel_wr,
  input  logic             cpu_tog,
  input  logic             auto_en,
  input  logic             byte_wr,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic             sel_q,
  output logic [1:0]       clr,
  output logic [1:0]       inc
);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LIMIT - 1);

  logic sel_d;
  logic fill_done;

  assign fill_done = auto_en && (cur_cnt >= LAST_V);

  always_comb begin
    sel_d = sel_q;
    clr   = '0;
    inc   = '0;
    if (cpu_sel_wr) begin
      sel_d        = cpu_tog;
      clr[cpu_tog] = 1'b1;
    end else if (byte_wr) begin
      inc[sel_q] = 1'b1;
      if (fill_done) begin
        sel_d       = ~sel_q;
        clr[~sel_q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= ppb_pkg::BUF_A;
    else     sel_q <= sel_d;
  end

  // R3/R5: a qualified write lands its toggle value in the selection
  p_cpu_select_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_sel_wr |=> sel_q == $past(cpu_tog));

  // R8: a filling strobe in auto mode flips the selection
  p_auto_switch_r8: assert property (@(posedge clk) disable iff (rst)
    (!cpu_sel_wr && byte_wr && auto_en && cur_cnt >= LAST_V) |=> sel_q != $past(sel_q));

  // R6: at most one buffer counts per cycle
  p_one_inc_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc));
endmodule

// File: rtl/ppb_err_flag.sv
module ppb_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic dir_q,
  input  logic tok_valid,
  input  logic tok_is_in,
  input  logic clr_req,
  output logic err_q
);
  logic set_req;

  // dir 1: IN is expected, OUT is wrong; dir 0: the reverse
  assign set_req = tok_valid && (dir_q ? !tok_is_in : tok_is_in);

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (set_req) err_q <= 1'b1;
    else if (clr_req) err_q <= 1'b0;
  end

  // R9: a wrong-direction token is always recorded
  p_wrong_dir_sets_r9: assert property (@(posedge clk) disable iff (rst)
    set_req |=> err_q);

  // R10: without a clear the flag holds
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_req) |=> err_q);
endmodule

// File: rtl/ppb_select.sv
module ppb_select #(
  parameter int unsigned BUF_BYTES = 512,
  parameter int unsigned CNT_W     = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             auto_toggle,
  input  logic             byte_wr,
  input  logic             tok_valid,
  input  logic             tok_is_in,
  output logic             buf_sel,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             ep_err,
  output logic             xfer_dir
);
  import ppb_pkg::*;

  localparam int unsigned NBUF = 2;

  logic             dir_q;
  logic             cpu_sel_wr;
  logic             err_clr;
  logic [NBUF-1:0]  clr;
  logic [NBUF-1:0]  inc;
  logic [CNT_W-1:0] cnt [NBUF];
  logic [CNT_W-1:0] cur_cnt;

  assign cpu_sel_wr = reg_wr && reg_wdata[BIT_TVALID];
  assign err_clr    = reg_wr && reg_wdata[BIT_ERR];

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= 1'b0;
    else if (reg_wr) dir_q <= reg_wdata[BIT_DIR];
  end

  ppb_sel_ctrl #(.LIMIT(BUF_BYTES), .CNT_W(CNT_W)) sel_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_sel_wr(cpu_sel_wr),
    .cpu_tog   (reg_wdata[BIT_TOG]),
    .auto_en   (auto_toggle),
    .byte_wr   (byte_wr),
    .cur_cnt   (cur_cnt),
    .sel_q     (buf_sel),
    .clr       (clr),
    .inc       (inc)
  );

  assign cur_cnt = buf_sel ? cnt[1] : cnt[0];

  for (genvar g = 0; g < NBUF; g++) begin : g_cnt
    ppb_byte_cnt #(.LIMIT(BUF_BYTES), .CNT_W(CNT_W)) cnt_i (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr[g]),
      .inc  (inc[g]),
      .count(cnt[g])
    );
  end

  ppb_err_flag err_i (
    .clk      (clk),
    .rst      (rst),
    .dir_q    (dir_q),
    .tok_valid(tok_valid),
    .tok_is_in(tok_is_in),
    .clr_req  (err_clr),
    .err_q    (ep_err)
  );

  assign cnt_a    = cnt[0];
  assign cnt_b    = cnt[1];
  assign xfer_dir = dir_q;

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[BIT_DIR] = dir_q;
    reg_rdata[BIT_TOG] = buf_sel;
    reg_rdata[BIT_ERR] = ep_err;
  end

  // R4: the qualifier bit never reads back
  p_valid_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[BIT_TVALID] == 1'b0);

  // R2: direction follows the last written bit 7
  p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> xfer_dir == $past(reg_wdata[BIT_DIR]));
endmodule

// File: tb/ppb_select_tb.sv
module ppb_select_tb_top;
  localparam int unsigned BUF_BYTES = 8;
  localparam int unsigned CNT_W     = $clog2(BUF_BYTES) + 1;

  logic clk = 1'b0;
  logic rst;
  logic reg_wr, auto_toggle, byte_wr, tok_valid, tok_is_in;
  logic [7:0] reg_wdata, reg_rdata;
  logic buf_sel, ep_err, xfer_dir;
  logic [CNT_W-1:0] cnt_a, cnt_b;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  ppb_select #(.BUF_BYTES(BUF_BYTES)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .auto_toggle(auto_toggle), .byte_wr(byte_wr),
    .tok_valid(tok_valid), .tok_is_in(tok_is_in), .buf_sel(buf_sel),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .ep_err(ep_err), .xfer_dir(xfer_dir)
  );

  // {wr, wdata, stb, tok_v, tok_in, exp_rdata, exp_a, exp_b, req}
  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd1, 4'd0, 4'd6},  // R6 count A
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd2, 4'd0, 4'd6},  // R6
    {1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2, 4'd0, 4'd3},  // R3 unqualified
    {1'b1, 8'h60, 1'b0, 1'b0, 1'b0, 8'h20, 4'd2, 4'd0, 4'd5},  // R5 pick B, R4
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h20, 4'd2, 4'd1, 4'd6},  // R6 count B
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h20, 4'd2, 4'd2, 4'd6},  // R6
    {1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 8'h00, 4'd0, 4'd2, 4'd5},  // R5 pick A
    {1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 8'h80, 4'd1, 4'd2, 4'd2},  // R2 dir
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h80, 4'd1, 4'd2, 4'd9},  // R9 IN ok
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h81, 4'd1, 4'd2, 4'd9},  // R9 OUT err
    {1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 8'h81, 4'd1, 4'd2, 4'd10}, // R10 hold
    {1'b1, 8'h81, 1'b0, 1'b0, 1'b0, 8'h80, 4'd1, 4'd2, 4'd10}, // R10 clear
    {1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 8'h01, 4'd1, 4'd2, 4'd10}, // R10 set wins
    {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1, 4'd2, 4'd10}, // R10
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h01, 4'd1, 4'd2, 4'd9},  // R9 IN err
    {1'b1, 8'h61, 1'b1, 1'b0, 1'b0, 8'h20, 4'd1, 4'd0, 4'd6}   // R6 write wins
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = '0; byte_wr = 0; tok_valid = 0; tok_is_in = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic check_all(input string req, input logic [7:0] rd,
                           input int a, input int b);
    check(req, "rdata", reg_rdata, rd);
    check(req, "cnt_a", 8'(cnt_a), 8'(a));
    check(req, "cnt_b", 8'(cnt_b), 8'(b));
  endtask

  initial begin
    #20000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    idle();
    auto_toggle = 0;
    rst = 1;
    #1;
    step(); step();
    rst = 0;
    // R1 reset state
    check_all("R1", 8'h00, 0, 0);
    check("R1", "buf_sel", 8'(buf_sel), 8'h0);

    for (int i = 0; i < NV; i++) begin
      reg_wr    = VEC[i][31];
      reg_wdata = VEC[i][30:23];
      byte_wr   = VEC[i][22];
      tok_valid = VEC[i][21];
      tok_is_in = VEC[i][20];
      step();
      check_all($sformatf("R%0d", VEC[i][3:0]), VEC[i][19:12],
                int'(VEC[i][11:8]), int'(VEC[i][7:4]));
    end

    // R7 saturation on B (selected, count 0) with auto off
    for (int k = 0; k < BUF_BYTES + 2; k++) begin
      byte_wr = 1; step();
    end
    check_all("R7", 8'h20, 1, BUF_BYTES);

    // R8 auto-toggle: refill A, then it switches to B and empties B
    reg_wr = 1; reg_wdata = 8'h40; step();
    check_all("R5", 8'h00, 0, BUF_BYTES);
    auto_toggle = 1;
    for (int k = 0; k < BUF_BYTES - 1; k++) begin
      byte_wr = 1; step();
    end
    check_all("R8", 8'h00, BUF_BYTES - 1, BUF_BYTES);
    byte_wr = 1; step();
    check_all("R8", 8'h20, BUF_BYTES, 0);
    check("R8", "buf_sel", 8'(buf_sel), 8'h1);
    byte_wr = 1; step();
    check_all("R8", 8'h20, BUF_BYTES, 1);
    auto_toggle = 0;

    // R1 reset again mid-run
    rst = 1; step(); rst = 0;
    check_all("R1", 8'h00, 0, 0);
    check("R1", "ep_err", 8'(ep_err), 8'h0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule